// File: doc/BRIEF.md
# Shared SRAM Arbiter for CPU and Raster Fetch

This block lets an 8-bit processor and a raster video fetch unit share one asynchronous SRAM. The processor's phase clock sets the slot boundary. While that clock is high the processor owns the memory. Its address drives the memory bus, its read and write strobes are qualified, and the data-path enables are opened in the right direction. While the clock is low the memory belongs to the video side. The video address drives the bus, a read strobe is asserted, and the returned byte is latched into the video data register on the dot clock.

One video byte is needed per dot clock, which is half a phase-clock period. The low half of each period therefore supplies only half of the demand. When the video side signals that a burst is due, the block pulls the processor's ready line low at the start of a read cycle. Ready is only honoured on reads, so a stall cannot begin on a write. Until the burst ends, the high half of each period also becomes a video slot, which gives the video side both halves. Ready rises one dot clock after the burst request drops.

The block runs on the dot clock with a synchronous active-high reset. The phase clock is an input that changes between dot-clock edges.

Top module: `sram_share_arb`

## Requirements
- R1: The memory address equals the CPU address when the phase clock is high and no stall is in force. In every other case it equals the video address. A low phase, or a high phase during a stall, is a video slot.
- R2: The enable for RAM data onto the CPU bus is high only when all of these hold: the cycle is a read (rw_n = 1), the phase clock is high, no stall is in force, reset is low, and every bit of the active-low peripheral select vector is 1.
- R3: The enable for CPU data onto the RAM bus is high only when all of these hold: the cycle is a write (rw_n = 0), the phase clock is high, no stall is in force, and reset is low.
- R4: The active-low write strobe is low only when all of these hold: the slot is a CPU slot, the cycle is a write, and reset is low. It is never low in a video slot.
- R5: The active-low read strobe is low, outside reset, in a CPU slot carrying a read and in every video slot.
- R6: At each dot-clock edge the video data register loads the memory byte if the slot is a video slot and the blank flag (the blank input delayed by one dot clock) is clear. Otherwise it loads zero.
- R7: Ready falls one dot clock after an edge that sees all of the following: the phase clock high where it was low at the previous edge, the burst request high, and a read cycle. A write cycle never starts a stall.
- R8: Once low, ready stays low while the burst request is high. It returns high one dot clock after an edge that sees the request low.
- R9: During reset and right after it, ready is high, the video data register holds zero, both data enables are low, and all memory strobes are high.
- R10: The active-low chip select is low whenever reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_i | input | 1 | CPU phase clock, high = CPU half |
| cpu_addr | input | 19 | CPU address |
| cpu_rw_n | input | 1 | 1 = read, 0 = write |
| cpu_dout | input | 8 | Data driven by the CPU |
| cpu_din | output | 8 | RAM data toward the CPU |
| cpu_din_oe | output | 1 | Enable for cpu_din onto the CPU bus |
| periph_sel_n | input | 2 | Active-low peripheral selects |
| ready | output | 1 | CPU ready, low = stall |
| vid_addr | input | 19 | Video fetch address |
| vid_blank | input | 1 | Blank flag from the timing unit |
| vid_burst | input | 1 | Request for double-rate fetch |
| vid_data | output | 8 | Captured video byte |
| mem_addr | output | 19 | SRAM address |
| mem_wdata | output | 8 | Data toward the SRAM |
| mem_wdata_oe | output | 1 | Enable for mem_wdata onto the SRAM bus |
| mem_rdata | input | 8 | Data from the SRAM |
| mem_ce_n | output | 1 | SRAM chip select, active low |
| mem_oe_n | output | 1 | SRAM read strobe, active low |
| mem_we_n | output | 1 | SRAM write strobe, active low |

## Verification
The properties assume that the phase clock changes only between dot-clock edges. They also assume that the CPU holds its address and read/write level steady while ready is low, as a stalled processor does. The stimulus changes every input half a dot clock away from the active edge and toggles the phase clock on every dot clock. It freezes the randomly drawn CPU address and direction for as long as the reference model sees a stall. Burst and blank requests are drawn as runs of several cycles, so stalls both start and release many times.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;

    localparam int unsigned DEF_ADDR_W = 19;
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_NSEL   = 2;

    typedef enum logic {
        OWNER_CPU = 1'b0,
        OWNER_VID = 1'b1
    } slot_owner_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } stall_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } mem_strobe_t;

    // The CPU keeps the high half unless a stall hands it to video.
    function automatic slot_owner_e pick_owner(input logic phase, input logic hold);
        return (phase && !hold) ? OWNER_CPU : OWNER_VID;
    endfunction

    function automatic mem_strobe_t make_strobes(input logic rst,
                                                 input slot_owner_e owner,
                                                 input logic rw_n);
        mem_strobe_t s;
        s.ce_n = rst;
        s.oe_n = rst || !((owner == OWNER_VID) || rw_n);
        s.we_n = rst || !((owner == OWNER_CPU) && !rw_n);
        return s;
    endfunction

endpackage

// File: rtl/cpu_stall_ctl.sv
module cpu_stall_ctl
    import sram_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic phase_i,
    input  logic cpu_rw_n,
    input  logic vid_burst,
    output logic hold,
    output logic ready
);

    stall_state_e state_q;
    logic         phase_q;
    logic         read_start;

    // A bus cycle starts when the phase clock rises; stall only on reads.
    assign read_start = phase_i && !phase_q && cpu_rw_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            phase_q <= 1'b0;
        end else begin
            phase_q <= phase_i;
            unique case (state_q)
                ST_RUN:  if (read_start && vid_burst) state_q <= ST_HOLD;
                ST_HOLD: if (!vid_burst)              state_q <= ST_RUN;
                default:                              state_q <= ST_RUN;
            endcase
        end
    end

    assign hold  = (state_q == ST_HOLD);
    assign ready = (state_q == ST_RUN);

endmodule

// File: rtl/sram_slot_mux.sv
module sram_slot_mux
    import sram_arb_pkg::*;
#(
    parameter int unsigned AW   = DEF_ADDR_W,
    parameter int unsigned DW   = DEF_DATA_W,
    parameter int unsigned NSEL = DEF_NSEL
) (
    input  logic            rst,
    input  logic            phase_i,
    input  logic            hold,
    input  logic [AW-1:0]   cpu_addr,
    input  logic            cpu_rw_n,
    input  logic [DW-1:0]   cpu_dout,
    input  logic [NSEL-1:0] periph_sel_n,
    input  logic [AW-1:0]   vid_addr,
    input  logic [DW-1:0]   mem_rdata,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_wdata_oe,
    output logic [DW-1:0]   cpu_din,
    output logic            cpu_din_oe,
    output mem_strobe_t     strobes,
    output logic            vid_slot
);

    slot_owner_e owner;
    logic        cpu_slot;
    logic        no_periph;

    assign owner     = pick_owner(phase_i, hold);
    assign cpu_slot  = (owner == OWNER_CPU);
    assign vid_slot  = (owner == OWNER_VID);
    assign no_periph = &periph_sel_n;

    always_comb begin
        mem_addr     = cpu_slot ? cpu_addr : vid_addr;
        mem_wdata    = cpu_dout;
        cpu_din      = mem_rdata;
        mem_wdata_oe = cpu_slot && !cpu_rw_n && !rst;
        cpu_din_oe   = cpu_slot && cpu_rw_n && !rst && no_periph;
        strobes      = make_strobes(rst, owner, cpu_rw_n);
    end

endmodule

// File: rtl/vid_capture.sv
module vid_capture
    import sram_arb_pkg::*;
#(
    parameter int unsigned DW = DEF_DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vid_slot,
    input  logic          vid_blank,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] vid_data
);

    logic blank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_q  <= 1'b1;
            vid_data <= '0;
        end else begin
            blank_q  <= vid_blank;
            vid_data <= (vid_slot && !blank_q) ? mem_rdata : '0;
        end
    end

endmodule

// File: rtl/sram_share_arb.sv
module sram_share_arb
    import sram_arb_pkg::*;
#(
    parameter int unsigned AW   = DEF_ADDR_W,
    parameter int unsigned DW   = DEF_DATA_W,
    parameter int unsigned NSEL = DEF_NSEL
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            phase_i,
    input  logic [AW-1:0]   cpu_addr,
    input  logic            cpu_rw_n,
    input  logic [DW-1:0]   cpu_dout,
    output logic [DW-1:0]   cpu_din,
    output logic            cpu_din_oe,
    input  logic [NSEL-1:0] periph_sel_n,
    output logic            ready,
    input  logic [AW-1:0]   vid_addr,
    input  logic            vid_blank,
    input  logic            vid_burst,
    output logic [DW-1:0]   vid_data,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_wdata_oe,
    input  logic [DW-1:0]   mem_rdata,
    output logic            mem_ce_n,
    output logic            mem_oe_n,
    output logic            mem_we_n
);

    logic        hold;
    logic        vid_slot;
    mem_strobe_t strobes;

    cpu_stall_ctl u_stall (
        .clk       (clk),
        .rst       (rst),
        .phase_i   (phase_i),
        .cpu_rw_n  (cpu_rw_n),
        .vid_burst (vid_burst),
        .hold      (hold),
        .ready     (ready)
    );

    sram_slot_mux #(.AW(AW), .DW(DW), .NSEL(NSEL)) u_mux (
        .rst          (rst),
        .phase_i      (phase_i),
        .hold         (hold),
        .cpu_addr     (cpu_addr),
        .cpu_rw_n     (cpu_rw_n),
        .cpu_dout     (cpu_dout),
        .periph_sel_n (periph_sel_n),
        .vid_addr     (vid_addr),
        .mem_rdata    (mem_rdata),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_wdata_oe (mem_wdata_oe),
        .cpu_din      (cpu_din),
        .cpu_din_oe   (cpu_din_oe),
        .strobes      (strobes),
        .vid_slot     (vid_slot)
    );

    vid_capture #(.DW(DW)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .vid_slot  (vid_slot),
        .vid_blank (vid_blank),
        .mem_rdata (mem_rdata),
        .vid_data  (vid_data)
    );

    assign mem_ce_n = strobes.ce_n;
    assign mem_oe_n = strobes.oe_n;
    assign mem_we_n = strobes.we_n;

endmodule

// File: rtl/sram_share_arb_chk.sv
module sram_share_arb_chk #(
    parameter int unsigned AW   = 19,
    parameter int unsigned NSEL = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            phase_i,
    input logic            cpu_rw_n,
    input logic [NSEL-1:0] periph_sel_n,
    input logic            cpu_din_oe,
    input logic            ready,
    input logic [AW-1:0]   vid_addr,
    input logic            vid_burst,
    input logic [AW-1:0]   mem_addr,
    input logic            mem_wdata_oe,
    input logic            mem_we_n,
    input logic            mem_ce_n
);

    p_vid_addr_low_phase_r1: assert property (@(posedge clk) disable iff (rst)
        !phase_i |-> (mem_addr == vid_addr));

    p_cpu_drive_qual_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_din_oe |-> (cpu_rw_n && phase_i && ready && (&periph_sel_n)));

    p_ram_drive_qual_r3: assert property (@(posedge clk) disable iff (rst)
        mem_wdata_oe |-> (!cpu_rw_n && phase_i && ready));

    p_no_write_video_r4: assert property (@(posedge clk) disable iff (rst)
        (!phase_i || !ready) |-> mem_we_n);

    p_stall_on_read_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> ($past(cpu_rw_n) && $past(vid_burst)));

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (!ready && !vid_burst) |=> ready);

    p_chip_select_r10: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n);

endmodule

bind sram_share_arb sram_share_arb_chk #(.AW(AW), .NSEL(NSEL)) u_chk (.*);

// File: tb/sram_share_arb_tb.sv
`timescale 1ns/1ps
module sram_share_arb_tb;

    localparam int AW = 19;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          phase_i;
    logic [AW-1:0] cpu_addr;
    logic          cpu_rw_n;
    logic [DW-1:0] cpu_dout;
    logic [DW-1:0] cpu_din;
    logic          cpu_din_oe;
    logic [1:0]    periph_sel_n;
    logic          ready;
    logic [AW-1:0] vid_addr;
    logic          vid_blank;
    logic          vid_burst;
    logic [DW-1:0] vid_data;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_wdata_oe;
    logic [DW-1:0] mem_rdata;
    logic          mem_ce_n;
    logic          mem_oe_n;
    logic          mem_we_n;

    logic [DW-1:0] sram [256];
    int unsigned   n_chk = 0;
    int unsigned   n_bad = 0;
    logic          done  = 1'b0;

    // reference model state
    logic          m_st, m_pb, m_phq;
    logic [DW-1:0] m_vd;

    always #2 clk = ~clk;

    assign mem_rdata = sram[mem_addr[7:0]];

    always @(posedge clk) begin
        if (!mem_we_n && mem_wdata_oe) sram[mem_addr[7:0]] <= mem_wdata;
    end

    sram_share_arb u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_cpu_slot(input logic ph, input logic st);
        return ph && !st;
    endfunction

    function automatic logic exp_next_stall(input logic st, input logic ph, input logic phq,
                                            input logic rw, input logic bu);
        if (!st) return ph && !phq && rw && bu;
        return bu;
    endfunction

    task automatic step(input logic ph, input logic [AW-1:0] ca, input logic rw,
                        input logic [DW-1:0] cd, input logic [1:0] ps,
                        input logic [AW-1:0] va, input logic bl, input logic bu);
        logic cs;
        logic n_st, n_pb, n_phq;
        logic [DW-1:0] n_vd;
        phase_i = ph; cpu_addr = ca; cpu_rw_n = rw; cpu_dout = cd;
        periph_sel_n = ps; vid_addr = va; vid_blank = bl; vid_burst = bu;
        #1;
        cs = exp_cpu_slot(ph, m_st);
        check("R1", mem_addr, cs ? ca : va);
        check("R2", cpu_din_oe, cs && rw && !rst && (&ps));
        check("R3", mem_wdata_oe, cs && !rw && !rst);
        check("R4", mem_we_n, !(cs && !rw && !rst));
        check("R5", mem_oe_n, !(!rst && (!cs || rw)));
        check("R10", mem_ce_n, rst);
        if (rst) begin
            n_st = 1'b0; n_pb = 1'b1; n_phq = 1'b0; n_vd = '0;
        end else begin
            n_st  = exp_next_stall(m_st, ph, m_phq, rw, bu);
            n_pb  = bl;
            n_phq = ph;
            n_vd  = (!cs && !m_pb) ? sram[va[7:0]] : '0;
        end
        @(posedge clk);
        #1;
        m_st = n_st; m_pb = n_pb; m_phq = n_phq; m_vd = n_vd;
        check("R6", vid_data, m_vd);
        check("R7", ready, !m_st);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic ph;
        logic [AW-1:0] ca;
        logic rw;
        int burst_left;
        int blank_left;
        logic bu, bl;
        void'($urandom(32'h00c0ffee));
        for (int i = 0; i < 256; i++) sram[i] = 8'(i * 37 + 5);
        m_st = 1'b0; m_pb = 1'b1; m_phq = 1'b0; m_vd = '0;
        rst = 1'b1;
        @(negedge clk);
        // R9: reset state
        for (int i = 0; i < 3; i++) begin
            step(i[0], 19'h1234, 1'b0, 8'hAA, 2'b11, 19'h0040, 1'b0, 1'b1);
            check("R9", {ready, vid_data, cpu_din_oe, mem_wdata_oe, mem_oe_n, mem_we_n},
                  {1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1});
        end
        rst = 1'b0;
        // R7: write cycle with burst pending never stalls
        step(1'b0, 19'h00010, 1'b0, 8'h5A, 2'b11, 19'h00020, 1'b0, 1'b1);
        step(1'b1, 19'h00010, 1'b0, 8'h5A, 2'b11, 19'h00021, 1'b0, 1'b1);
        check("R7", ready, 1'b1);
        step(1'b0, 19'h00010, 1'b0, 8'h5A, 2'b11, 19'h00022, 1'b0, 1'b1);
        // R7/R1: read cycle starts stall; high phase then belongs to video
        step(1'b1, 19'h00033, 1'b1, 8'h00, 2'b11, 19'h00023, 1'b0, 1'b1);
        check("R7", ready, 1'b0);
        step(1'b0, 19'h00033, 1'b1, 8'h00, 2'b11, 19'h00024, 1'b0, 1'b1);
        step(1'b1, 19'h00033, 1'b1, 8'h00, 2'b11, 19'h00025, 1'b0, 1'b1);
        // R8: release one clock after burst drops
        step(1'b0, 19'h00033, 1'b1, 8'h00, 2'b11, 19'h00026, 1'b0, 1'b0);
        check("R8", ready, 1'b1);
        // R2: peripheral select blocks the CPU data drive
        step(1'b1, 19'h00044, 1'b1, 8'h00, 2'b01, 19'h00027, 1'b0, 1'b0);
        step(1'b0, 19'h00044, 1'b1, 8'h00, 2'b10, 19'h00028, 1'b1, 1'b0);
        // R6: blank delayed one clock forces zero
        step(1'b1, 19'h00044, 1'b1, 8'h00, 2'b11, 19'h00029, 1'b0, 1'b0);
        step(1'b0, 19'h00044, 1'b1, 8'h00, 2'b11, 19'h0002A, 1'b0, 1'b0);

        // constrained random mix
        ph = 1'b1; ca = '0; rw = 1'b1; burst_left = 0; blank_left = 0; bu = 1'b0; bl = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (burst_left == 0) begin
                bu = ($urandom_range(0, 3) == 0);
                burst_left = $urandom_range(1, 10);
            end
            burst_left--;
            if (blank_left == 0) begin
                bl = ($urandom_range(0, 2) == 0);
                blank_left = $urandom_range(1, 12);
            end
            blank_left--;
            if (!m_st && ph) begin
                ca = AW'($urandom);
                rw = $urandom_range(0, 1) == 1;
            end
            ph = ~ph;
            step(ph, ca, rw, 8'($urandom),
                 ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b11,
                 AW'($urandom), bl, bu);
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule